// File: doc/BRIEF.md
# Multi-Operation Media Arithmetic Unit

This block is a compact arithmetic unit for media and signal-processing kernels. Each cycle it takes two unsigned 8-bit operands and a 3-bit operation code. It returns one of six results: sum, difference, product, rounded average, running sum of absolute differences, or running multiply-accumulate. All operations share one datapath, built as a radix-4 Booth partial-product generator, a reduction stage and an accumulation stage. A small decoder steers the datapath from the operation code.

Each arithmetic sub-circuit (adder, multiplier, absolute-difference unit) is fed through an operand freezer. When the current operation does not use that sub-circuit, or no operation is issued, the freezer keeps presenting the operands it last passed on. The sub-circuit's inputs therefore do not toggle, which saves switching power. The two accumulators are cleared by a dedicated input. A result and its valid flag leave the block one clock after the operation is issued.

Top module: `media_alu`

## Requirements
- R1: Code 3'b000 (add) returns the 9-bit sum A+B, zero-extended to 24 bits.
- R2: Code 3'b010 (subtract) returns A−B as a 24-bit two's-complement value.
- R3: Code 3'b001 (multiply) returns the unsigned 16-bit product A×B, zero-extended.
- R4: Code 3'b110 (interpolate) returns the rounded average (A+B+1)>>1.
- R5: Code 3'b100 (SAD) adds |A−B| into a 16-bit accumulator that wraps modulo 2^16. The result is the updated accumulator, zero-extended.
- R6: Code 3'b111 (MAC) adds A×B into a separate 24-bit accumulator that wraps modulo 2^24. The result is the updated accumulator.
- R7: A high clear input zeroes both accumulators. When it coincides with a valid SAD or MAC operation, that operation's accumulator starts from zero and takes the new term.
- R8: Codes 3'b011 and 3'b101 return zero and leave both accumulators unchanged.
- R9: The result and the valid output are registered and appear one cycle after valid input. Without a valid input the valid output drops and the result holds.
- R10: Operands reaching the adder, multiplier and absolute-difference circuits stay frozen whenever that circuit is unused. A circuit used again after a frozen stretch gives the correct result.
- R11: After reset the result is zero, valid is low and both accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| op_i | input | 3 | Operation code |
| valid_i | input | 1 | Operation issued this cycle |
| clear_i | input | 1 | Zero both accumulators |
| result_o | output | 24 | Registered result |
| valid_o | output | 1 | Result valid |

## Verification
A clear can arrive in the same cycle as a SAD or MAC step, so the clear and the accumulation both act on one register at one edge. The bench provokes this twice. First, clear is raised together with a SAD operation: the result must be the fresh |A−B| alone, and a later MAC must show that its own accumulator was zeroed. Second, clear is raised together with a MAC operation, with the mirror-image check on the SAD accumulator. The scoreboard model applies the clear before the step and compares every returned value.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_MUL  = 3'b001,
    OP_SUB  = 3'b010,
    OP_NOP3 = 3'b011,
    OP_SAD  = 3'b100,
    OP_NOP5 = 3'b101,
    OP_AVG  = 3'b110,
    OP_MAC  = 3'b111
  } op_e;

  // Radix-4 recoding of one overlapping 3-bit multiplier group: {neg, two, one}
  function automatic logic [2:0] booth_code(input logic [2:0] grp);
    case (grp)
      3'b001, 3'b010: booth_code = 3'b001;
      3'b011:         booth_code = 3'b010;
      3'b100:         booth_code = 3'b110;
      3'b101, 3'b110: booth_code = 3'b101;
      default:        booth_code = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/media_alu_decode.sv
module media_alu_decode
  import media_alu_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       valid_i,
  output logic       use_add,
  output logic       add_neg,
  output logic       add_cin,
  output logic       use_mul,
  output logic       use_sad,
  output logic       step_sad,
  output logic       step_mac
);
  always_comb begin
    use_add  = 1'b0;
    add_neg  = 1'b0;
    add_cin  = 1'b0;
    use_mul  = 1'b0;
    use_sad  = 1'b0;
    step_sad = 1'b0;
    step_mac = 1'b0;
    if (valid_i) begin
      case (op_i)
        OP_ADD: use_add = 1'b1;
        OP_SUB: begin use_add = 1'b1; add_neg = 1'b1; add_cin = 1'b1; end
        OP_AVG: begin use_add = 1'b1; add_cin = 1'b1; end
        OP_MUL: use_mul = 1'b1;
        OP_MAC: begin use_mul = 1'b1; step_mac = 1'b1; end
        OP_SAD: begin use_sad = 1'b1; step_sad = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/media_alu_freeze.sv
module media_alu_freeze #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic [W-1:0] a_hold, b_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold <= '0;
      b_hold <= '0;
    end else if (en) begin
      a_hold <= a_i;
      b_hold <= b_i;
    end
  end

  assign a_o = en ? a_i : a_hold;
  assign b_o = en ? b_i : b_hold;
endmodule

// File: rtl/media_alu_booth.sv
module media_alu_booth
  import media_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [2*W-1:0] prod_o
);
  localparam int NDIG = (W + 2) / 2;
  localparam int YW   = 2 * NDIG;
  localparam int PW   = 2 * W;

  logic [YW:0]   y_ext;
  logic [PW-1:0] x_ext;
  logic [PW-1:0] pp [NDIG];

  assign y_ext = {{(YW-W){1'b0}}, y_i, 1'b0};
  assign x_ext = {{(PW-W){1'b0}}, x_i};

  // partial-product generation: one recoded digit per pair of multiplier bits
  for (genvar i = 0; i < NDIG; i++) begin : g_pp
    logic [2:0]    code;
    logic [PW-1:0] mag;
    assign code  = booth_code(y_ext[2*i+2 -: 3]);
    assign mag   = code[1] ? (x_ext << 1) : (code[0] ? x_ext : '0);
    assign pp[i] = (code[2] ? (~mag + 1'b1) : mag) << (2 * i);
  end

  // reduction: modulo-2^PW sum of the shifted partial products
  always_comb begin
    prod_o = '0;
    for (int k = 0; k < NDIG; k++) prod_o = prod_o + pp[k];
  end
endmodule

// File: rtl/media_alu.sv
module media_alu
  import media_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int SAD_W = 16,
  parameter int MAC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [2:0]       op_i,
  input  logic             valid_i,
  input  logic             clear_i,
  output logic [MAC_W-1:0] result_o,
  output logic             valid_o
);
  localparam int RES_W = MAC_W;
  localparam int AW    = W + 2;

  function automatic logic [W-1:0] abs_diff(input logic [W-1:0] p, input logic [W-1:0] q);
    return (p >= q) ? (p - q) : (q - p);
  endfunction

  function automatic logic [AW-1:0] add_core(input logic [W-1:0] p, input logic [W-1:0] q,
                                             input logic neg, input logic cin);
    logic [AW-1:0] qx;
    qx = {2'b00, q} ^ {AW{neg}};
    return {2'b00, p} + qx + {{(AW-1){1'b0}}, cin};
  endfunction

  logic use_add, add_neg, add_cin, use_mul, use_sad, step_sad, step_mac;
  logic [W-1:0] add_a, add_b, mul_a, mul_b, sad_a, sad_b;
  logic [AW-1:0]    sum_ext;
  logic [2*W-1:0]   prod;
  logic [SAD_W-1:0] sad_acc, sad_next;
  logic [MAC_W-1:0] mac_acc, mac_next;
  logic [RES_W-1:0] result_c, result_q;
  logic             valid_q;

  media_alu_decode u_dec (
    .op_i(op_i), .valid_i(valid_i), .use_add(use_add), .add_neg(add_neg),
    .add_cin(add_cin), .use_mul(use_mul), .use_sad(use_sad),
    .step_sad(step_sad), .step_mac(step_mac)
  );

  media_alu_freeze #(.W(W)) u_frz_add (
    .clk(clk), .rst_n(rst_n), .en(use_add), .a_i(a_i), .b_i(b_i), .a_o(add_a), .b_o(add_b)
  );
  media_alu_freeze #(.W(W)) u_frz_mul (
    .clk(clk), .rst_n(rst_n), .en(use_mul), .a_i(a_i), .b_i(b_i), .a_o(mul_a), .b_o(mul_b)
  );
  media_alu_freeze #(.W(W)) u_frz_sad (
    .clk(clk), .rst_n(rst_n), .en(use_sad), .a_i(a_i), .b_i(b_i), .a_o(sad_a), .b_o(sad_b)
  );

  media_alu_booth #(.W(W)) u_mul (.x_i(mul_a), .y_i(mul_b), .prod_o(prod));

  assign sum_ext  = add_core(add_a, add_b, add_neg, add_cin);
  assign sad_next = (clear_i ? '0 : sad_acc) + {{(SAD_W-W){1'b0}}, abs_diff(sad_a, sad_b)};
  assign mac_next = (clear_i ? '0 : mac_acc) + {{(MAC_W-2*W){1'b0}}, prod};

  // accumulation stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_acc <= '0;
      mac_acc <= '0;
    end else begin
      if (step_sad)     sad_acc <= sad_next;
      else if (clear_i) sad_acc <= '0;
      if (step_mac)     mac_acc <= mac_next;
      else if (clear_i) mac_acc <= '0;
    end
  end

  always_comb begin
    case (op_i)
      OP_ADD:  result_c = {{(RES_W-AW){1'b0}}, sum_ext};
      OP_SUB:  result_c = {{(RES_W-AW){sum_ext[AW-1]}}, sum_ext};
      OP_AVG:  result_c = {{(RES_W-W){1'b0}}, sum_ext[W:1]};
      OP_MUL:  result_c = {{(RES_W-2*W){1'b0}}, prod};
      OP_SAD:  result_c = {{(RES_W-SAD_W){1'b0}}, sad_next};
      OP_MAC:  result_c = mac_next;
      default: result_c = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= result_c;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/media_alu_checker.sv
module media_alu_checker #(
  parameter int W     = 8,
  parameter int SAD_W = 16,
  parameter int MAC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic             clear_i,
  input logic [2:0]       op_i,
  input logic [MAC_W-1:0] result_o,
  input logic             valid_o,
  input logic [SAD_W-1:0] sad_acc,
  input logic [MAC_W-1:0] mac_acc,
  input logic             use_add,
  input logic             use_mul,
  input logic             use_sad,
  input logic [W-1:0]     add_a,
  input logic [W-1:0]     add_b,
  input logic [W-1:0]     mul_a,
  input logic [W-1:0]     mul_b,
  input logic [W-1:0]     sad_a,
  input logic [W-1:0]     sad_b
);
  logic primed;
  logic spare_op, sad_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assign spare_op = valid_i && (op_i == 3'b011 || op_i == 3'b101);
  assign sad_step = valid_i && (op_i == 3'b100);

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o));
  assert_spare_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spare_op |=> (result_o == '0));
  assert_spare_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_op && !clear_i) |=> ($stable(sad_acc) && $stable(mac_acc)));
  assert_clear_sad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !sad_step) |=> (sad_acc == '0));
  assert_freeze_add_R10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !use_add |-> (add_a == $past(add_a) && add_b == $past(add_b)));
  assert_freeze_mul_R10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !use_mul |-> (mul_a == $past(mul_a) && mul_b == $past(mul_b)));
  assert_freeze_sad_R10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !use_sad |-> (sad_a == $past(sad_a) && sad_b == $past(sad_b)));
  assert_one_unit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({use_add, use_mul, use_sad}));
endmodule

bind media_alu media_alu_checker #(.W(W), .SAD_W(SAD_W), .MAC_W(MAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clear_i(clear_i), .op_i(op_i),
  .result_o(result_o), .valid_o(valid_o), .sad_acc(sad_acc), .mac_acc(mac_acc),
  .use_add(use_add), .use_mul(use_mul), .use_sad(use_sad),
  .add_a(add_a), .add_b(add_b), .mul_a(mul_a), .mul_b(mul_b),
  .sad_a(sad_a), .sad_b(sad_b)
);

// File: tb/media_alu_bench.sv
`timescale 1ns/1ps
module media_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic [2:0]  op_i = '0;
  logic        valid_i = 1'b0, clear_i = 1'b0;
  logic [23:0] result_o;
  logic        valid_o;

  typedef struct { logic [23:0] v; string req; } exp_t;
  exp_t exp_q[$];
  int total = 0, bad = 0;
  int sad_m = 0, mac_m = 0;
  logic [23:0] last_v = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  media_alu u_media_alu (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .valid_i(valid_i), .clear_i(clear_i), .result_o(result_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: issue one operation and push the model's answer
  task automatic drive(input logic [2:0] op, input int a, input int b, input bit clr, input string req);
    exp_t e;
    int d;
    @(negedge clk);
    op_i = op; a_i = a[7:0]; b_i = b[7:0]; clear_i = clr; valid_i = 1'b1;
    if (clr) begin sad_m = 0; mac_m = 0; end
    case (op)
      3'b000: d = a + b;
      3'b010: d = a - b;
      3'b001: d = a * b;
      3'b110: d = (a + b + 1) / 2;
      3'b100: begin sad_m = (sad_m + ((a > b) ? a - b : b - a)) % 65536; d = sad_m; end
      3'b111: begin mac_m = (mac_m + a * b) % 16777216; d = mac_m; end
      default: d = 0;
    endcase
    e.v = d[23:0];
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input bit clr);
    @(negedge clk);
    valid_i = 1'b0; clear_i = clr;
    if (clr) begin sad_m = 0; mac_m = 0; end
  endtask

  // monitor: compare each produced result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) chk("R9 unexpected valid", 24'h0, 24'h1);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, result_o, e.v);
        last_v = e.v;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset result", result_o, 24'h0);
    chk("R11 reset valid", {23'h0, valid_o}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after release", {result_o[22:0], valid_o}, 24'h0);

    drive(3'b000, 200, 100, 0, "R1 add");
    drive(3'b000, 255, 255, 0, "R1 add max");
    drive(3'b010, 5, 9, 0, "R2 sub negative");
    drive(3'b010, 200, 3, 0, "R2 sub positive");
    drive(3'b001, 255, 255, 0, "R3 mul max");
    drive(3'b001, 13, 11, 0, "R3 mul");
    drive(3'b001, 128, 3, 0, "R3 mul msb");
    drive(3'b110, 3, 4, 0, "R4 avg round up");
    drive(3'b110, 255, 254, 0, "R4 avg high");
    drive(3'b110, 0, 1, 0, "R4 avg low");
    drive(3'b000, 1, 2, 0, "R9 last before idle");
    idle(0);
    idle(0);
    chk("R9 valid low when idle", {23'h0, valid_o}, 24'h0);
    chk("R9 result holds", result_o, 24'd3);

    // R11: accumulators start at zero
    drive(3'b100, 10, 3, 0, "R5 R11 sad first");
    drive(3'b100, 3, 10, 0, "R5 sad swapped");
    drive(3'b111, 16, 16, 0, "R6 R11 mac first");
    drive(3'b111, 255, 255, 0, "R6 mac");
    drive(3'b011, 9, 9, 0, "R8 code 011 zero");
    drive(3'b101, 200, 7, 0, "R8 code 101 zero");
    drive(3'b100, 4, 4, 0, "R8 sad unchanged");
    drive(3'b111, 0, 0, 0, "R8 mac unchanged");

    // R10: units used again after frozen stretches
    drive(3'b000, 17, 34, 0, "R10 add after freeze");
    drive(3'b001, 7, 9, 0, "R10 mul after freeze");
    drive(3'b100, 0, 50, 0, "R10 sad after freeze");

    // R7: clear coinciding with accumulation
    drive(3'b100, 1, 5, 1, "R7 clear with sad");
    drive(3'b111, 0, 0, 0, "R7 mac cleared too");
    drive(3'b111, 2, 3, 1, "R7 clear with mac");
    drive(3'b100, 0, 0, 0, "R7 sad cleared too");
    idle(1);
    drive(3'b111, 1, 1, 0, "R7 clear alone");

    // wrap-around of both accumulators
    for (int i = 0; i < 260; i++) drive(3'b100, 255, 0, 0, "R5 sad wrap");
    for (int i = 0; i < 260; i++) drive(3'b111, 255, 255, 0, "R6 mac wrap");
    for (int i = 0; i < 40; i++) drive(3'(i % 8), (i * 37) % 256, (i * 91) % 256, 0, "R9 back to back");
    idle(0);
    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", 24'(exp_q.size()), 24'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule